// File: doc/BRIEF.md
# Four-Channel DMA Transfer-Mode Sequencer

This block sequences DMA service for four channels. Each channel keeps a six-bit mode, a working address and count, and reload copies of both. The block watches one request line per channel and a shared end-of-process input. It grants one channel at a time and, while a grant is held, drives a one-hot acknowledge, a transfer strobe, the working address and the transfer type of each cycle.

Channels are configured through a parallel load port, one register per write. A channel can run in demand, single, block or cascade service. Its address can step up or down, and it can reload itself when a run completes. Bus timing, page extension and memory-to-memory copies belong to the surrounding logic.

Every active cycle of a granted non-cascade channel is one transfer. The count register holds N-1 for N transfers. Terminal count is the transfer made while the count reads zero.

Top module: `dma_quad_seq`

## Requirements
- R1: After a synchronous active-low reset, every acknowledge and the strobe are low, and all four channels are masked, so no request is answered until a channel is unmasked.
- R2: A load-port write with `ld_en` high selects a register of channel `ld_chan` by `ld_sel`: 0 loads the mode from `ld_data[7:2]`, 1 loads the address, 2 loads the count and 3 loads the mask from `ld_data[0]`. Address and count writes set both the base and the working copy.
- R3: In a cycle with no grant, the lowest-numbered channel that requests, is unmasked and is armed wins. Its acknowledge appears in the following cycle. The grant stays on that channel until its burst ends, and at most one acknowledge is high.
- R4: Single service (mode bits 7:6 = 01) makes exactly one transfer per grant. The channel is not granted again until its request has been low for at least one clock edge.
- R5: Demand service (00) transfers in every cycle in which the granted request is high. The burst ends at the first cycle with the request low, at terminal count or at end-of-process. A later burst continues from the current address and count.
- R6: Block service (10) keeps transferring on every cycle after the grant, whether or not the request stays high, until terminal count or end-of-process.
- R7: Cascade service (11) drives the granted channel's acknowledge equal to its request and never raises the strobe. The grant is dropped in the first cycle the request is low.
- R8: After each transfer the working address steps by one. It steps down when mode bit 5 is set and up when it is clear.
- R9: After each transfer the count decrements. `tc` is high only in the transfer made while the count is zero, so a count of N-1 gives N transfers with one `tc` pulse.
- R10: End-of-process sampled high during a transfer completes the channel at that transfer, exactly as terminal count does.
- R11: When mode bit 4 is clear, completion sets the channel's mask, and later requests from that channel go unanswered.
- R12: When mode bit 4 is set, completion reloads the working address and count from the base copies and leaves the channel unmasked.
- R13: During a transfer, `dir` shows mode bits 3:2 (00 verify, 01 read, 10 write). Outside a transfer, `dir` and `addr` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_chan | input | 2 | Channel addressed by the write |
| ld_sel | input | 2 | Register select: 0 mode, 1 address, 2 count, 3 mask |
| ld_data | input | 16 | Write data |
| dreq | input | 4 | Per-channel service requests |
| eop | input | 1 | End-of-process, shared by all channels |
| dack | output | 4 | One-hot acknowledge of the granted channel |
| xfer | output | 1 | High in each cycle that performs a transfer |
| addr | output | 16 | Working address of the current transfer |
| dir | output | 2 | Transfer type of the current transfer |
| tc | output | 1 | Terminal-count pulse |

## Verification
The embedded properties check the following on every cycle:
- at most one acknowledge is high, and a grant stays put while its burst is open;
- a single-service grant closes after its transfer, and a block burst never closes before completion;
- cascade never strobes;
- a `tc` or end-of-process transfer is followed by release;
- the per-channel count and address step, mask setting and reload happen at completion.

The bench's scenarios are the only place to see request ordering across channels, the pause and resume of demand bursts, the re-arming of single service after a request drops, and the reloaded starting address seen on a later burst.

// File: rtl/dmaq_pkg.sv
// Package: shared encodings for the four-channel DMA sequencer.
// Assumes the mode field sits in load data bits 7:2.
package dmaq_pkg;

    typedef enum logic [1:0] {
        SVC_DEMAND  = 2'b00,
        SVC_SINGLE  = 2'b01,
        SVC_BLOCK   = 2'b10,
        SVC_CASCADE = 2'b11
    } svc_e;

    typedef enum logic [1:0] {
        LD_MODE  = 2'b00,
        LD_ADDR  = 2'b01,
        LD_COUNT = 2'b10,
        LD_MASK  = 2'b11
    } ldsel_e;

    typedef enum logic [1:0] {
        XT_VERIFY = 2'b00,
        XT_READ   = 2'b01,
        XT_WRITE  = 2'b10,
        XT_RSVD   = 2'b11
    } xtype_e;

    // Field order matches load data bits 7:2, from MSB to LSB.
    typedef struct packed {
        svc_e   svc;
        logic   decr;
        logic   autoinit;
        xtype_e xtype;
    } chmode_t;

    localparam int MODE_LSB = 2;
    localparam int MODE_W   = 6;

endpackage

// File: rtl/dmaq_channel.sv
// Module: one DMA channel's register state.
// Holds the mode, base and working address and count, the mask bit and a
// re-arm flag for single service. Steps, reloads and masks on the strobes
// from the burst controller. A load-port write to a register takes
// precedence over any update of that same register.
module dmaq_channel
    import dmaq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_hit,
    input  ldsel_e        ld_sel,
    input  logic [DW-1:0] ld_data,
    input  logic          step,
    input  logic          done,
    input  logic          single_fire,
    input  logic          dreq,
    output svc_e          svc_o,
    output xtype_e        xtype_o,
    output logic [AW-1:0] addr_o,
    output logic          cnt_zero_o,
    output logic          armed_o
);

    chmode_t       mode_q;
    logic [AW-1:0] base_addr_q, cur_addr_q;
    logic [CW-1:0] base_cnt_q, cur_cnt_q;
    logic          mask_q;
    logic          rearm_q;

    // Mode register: written only from the load port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (ld_hit && ld_sel == LD_MODE)
            mode_q <= chmode_t'(ld_data[MODE_LSB +: MODE_W]);
    end

    // Address: load, reload on auto-init completion, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            cur_addr_q  <= '0;
        end else if (ld_hit && ld_sel == LD_ADDR) begin
            base_addr_q <= ld_data[AW-1:0];
            cur_addr_q  <= ld_data[AW-1:0];
        end else if (done && mode_q.autoinit) begin
            cur_addr_q  <= base_addr_q;
        end else if (step) begin
            cur_addr_q  <= mode_q.decr ? cur_addr_q - AW'(1) : cur_addr_q + AW'(1);
        end
    end

    // Count: load, reload on auto-init completion, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt_q <= '0;
            cur_cnt_q  <= '0;
        end else if (ld_hit && ld_sel == LD_COUNT) begin
            base_cnt_q <= ld_data[CW-1:0];
            cur_cnt_q  <= ld_data[CW-1:0];
        end else if (done && mode_q.autoinit) begin
            cur_cnt_q  <= base_cnt_q;
        end else if (step) begin
            cur_cnt_q  <= cur_cnt_q - CW'(1);
        end
    end

    // Mask: set at reset and at completion without auto-init.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= 1'b1;
        else if (ld_hit && ld_sel == LD_MASK)
            mask_q <= ld_data[0];
        else if (done && !mode_q.autoinit)
            mask_q <= 1'b1;
    end

    // Re-arm flag: blocks single service until the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rearm_q <= 1'b0;
        else if (!dreq)
            rearm_q <= 1'b0;
        else if (single_fire)
            rearm_q <= 1'b1;
    end

    // Outputs towards the arbiter and the bus mux.
    assign svc_o      = mode_q.svc;
    assign xtype_o    = mode_q.xtype;
    assign addr_o     = cur_addr_q;
    assign cnt_zero_o = (cur_cnt_q == '0);
    assign armed_o    = dreq && !mask_q && !rearm_q;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !done && !ld_hit) |=> cur_cnt_q == $past(cur_cnt_q) - CW'(1)); // R9

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !done && !ld_hit) |=>
        cur_addr_q == ($past(mode_q.decr) ? $past(cur_addr_q) - AW'(1)
                                          : $past(cur_addr_q) + AW'(1))); // R8

    AST_MASK_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q.autoinit && !ld_hit) |=> mask_q); // R11

    AST_RELOAD_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q.autoinit && !ld_hit) |=>
        (cur_cnt_q == $past(base_cnt_q)) && (cur_addr_q == $past(base_addr_q)) && !mask_q); // R12

endmodule

// File: rtl/dmaq_prio.sv
// Module: fixed-priority picker.
// Returns the index of the lowest set request bit and whether any bit is set.
// Purely combinational.
module dmaq_prio #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0] req,
    output logic [IW-1:0]  idx,
    output logic           any
);

    // Scan from the top so that the lowest index is written last.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmaq_burst_ctl.sv
// Module: grant and burst sequencing.
// Holds the current grant. Decides in each active cycle whether a transfer
// happens and whether the burst closes, according to the granted channel's
// service. Assumes the channels report armed, count-zero and service inputs
// from their registered state.
module dmaq_burst_ctl
    import dmaq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       dreq,
    input  logic [NCH-1:0]       armed,
    input  logic [NCH-1:0]       cnt_zero,
    input  logic                 eop,
    input  logic [NCH-1:0][1:0]  svc_i,
    output logic [IW-1:0]        gnt_o,
    output logic [NCH-1:0]       dack_o,
    output logic                 xfer_o,
    output logic [NCH-1:0]       step_o,
    output logic [NCH-1:0]       done_o,
    output logic [NCH-1:0]       fire_o
);

    logic            active_q;
    logic [IW-1:0]   gnt_q;
    logic [IW-1:0]   pick;
    logic            pick_any;
    svc_e            gsvc;
    logic            greq;
    logic            gzero;
    logic [NCH-1:0]  gsel;
    logic            lane_on;
    logic            done_now;
    logic            burst_end;

    dmaq_prio #(.NCH(NCH), .IW(IW)) u_prio (
        .req (armed),
        .idx (pick),
        .any (pick_any)
    );

    // Select the granted channel's attributes.
    always_comb begin
        gsvc  = svc_e'(svc_i[gnt_q]);
        greq  = dreq[gnt_q];
        gzero = cnt_zero[gnt_q];
        gsel  = NCH'(1) << gnt_q;
    end

    // Cycle decision: acknowledge, transfer, completion and burst close.
    always_comb begin
        lane_on  = active_q && (gsvc == SVC_SINGLE || gsvc == SVC_BLOCK || greq);
        xfer_o   = lane_on && (gsvc != SVC_CASCADE);
        done_now = xfer_o && (gzero || eop);
        unique case (gsvc)
            SVC_DEMAND:  burst_end = !greq || done_now;
            SVC_SINGLE:  burst_end = xfer_o;
            SVC_BLOCK:   burst_end = done_now;
            default:     burst_end = !greq;
        endcase
        burst_end = active_q && burst_end;
    end

    // Grant register: open on a pick while idle, close at burst end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            gnt_q    <= '0;
        end else if (active_q) begin
            if (burst_end)
                active_q <= 1'b0;
        end else if (pick_any) begin
            active_q <= 1'b1;
            gnt_q    <= pick;
        end
    end

    // Per-channel strobes back to the channel registers.
    assign gnt_o  = gnt_q;
    assign dack_o = lane_on ? gsel : '0;
    assign step_o = xfer_o ? gsel : '0;
    assign done_o = done_now ? gsel : '0;
    assign fire_o = (xfer_o && gsvc == SVC_SINGLE) ? gsel : '0;

    AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack_o)); // R3

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !burst_end) |=> (active_q && $stable(gnt_q))); // R3

    AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && gsvc == SVC_SINGLE) |=> !active_q); // R4

    AST_BLOCK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && gsvc == SVC_BLOCK && !done_now) |=> xfer_o); // R6

    AST_CASC_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && gsvc == SVC_CASCADE) |-> !xfer_o); // R7

endmodule

// File: rtl/dma_quad_seq.sv
// Module: top of the four-channel DMA transfer-mode sequencer.
// Decodes the load port to the channel register sets and connects them to
// the burst controller. Drives address, type and terminal count from the
// granted channel. Assumes loads are single-cycle writes and that eop is
// synchronous to clk.
module dma_quad_seq
    import dmaq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int DW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_en,
    input  logic [CHW-1:0] ld_chan,
    input  logic [1:0]     ld_sel,
    input  logic [DW-1:0]  ld_data,
    input  logic [NCH-1:0] dreq,
    input  logic           eop,
    output logic [NCH-1:0] dack,
    output logic           xfer,
    output logic [AW-1:0]  addr,
    output logic [1:0]     dir,
    output logic           tc
);

    logic [NCH-1:0][1:0] svc_v;
    logic [NCH-1:0][1:0] xt_v;
    logic [AW-1:0]       ch_addr [NCH];
    logic [NCH-1:0]      cz_v, armed_v, step_v, done_v, fire_v;
    logic [CHW-1:0]      gnt;

    // One register set per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dmaq_channel #(.AW(AW), .CW(CW), .DW(DW)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .ld_hit      (ld_en && ld_chan == CHW'(c)),
            .ld_sel      (ldsel_e'(ld_sel)),
            .ld_data     (ld_data),
            .step        (step_v[c]),
            .done        (done_v[c]),
            .single_fire (fire_v[c]),
            .dreq        (dreq[c]),
            .svc_o       (svc_v[c]),
            .xtype_o     (xt_v[c]),
            .addr_o      (ch_addr[c]),
            .cnt_zero_o  (cz_v[c]),
            .armed_o     (armed_v[c])
        );
    end

    dmaq_burst_ctl #(.NCH(NCH), .IW(CHW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dreq     (dreq),
        .armed    (armed_v),
        .cnt_zero (cz_v),
        .eop      (eop),
        .svc_i    (svc_v),
        .gnt_o    (gnt),
        .dack_o   (dack),
        .xfer_o   (xfer),
        .step_o   (step_v),
        .done_o   (done_v),
        .fire_o   (fire_v)
    );

    // Bus-side outputs, zero outside a transfer.
    always_comb begin
        addr = xfer ? ch_addr[gnt] : '0;
        dir  = xfer ? xt_v[gnt]    : 2'b00;
        tc   = xfer && cz_v[gnt];
    end

    AST_TC_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (dack == '0)); // R9

    AST_EOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && eop) |=> !xfer); // R10

endmodule

// File: tb/tb_dma_quad_seq.sv
// Bench: behavioural reference model compared on every clock, plus
// scenario checks for each requirement.
module tb_dma_quad_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_chan = '0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic [3:0]  dreq = '0;
    logic        eop = 1'b0;
    logic [3:0]  dack;
    logic        xfer;
    logic [15:0] addr;
    logic [1:0]  dir;
    logic        tc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_quad_seq dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_chan(ld_chan),
        .ld_sel(ld_sel), .ld_data(ld_data), .dreq(dreq), .eop(eop),
        .dack(dack), .xfer(xfer), .addr(addr), .dir(dir), .tc(tc)
    );

    int checks = 0;
    int fails = 0;
    bit fin = 1'b0;

    // Reference model state.
    int m_mode [4];
    int m_baddr [4];
    int m_caddr [4];
    int m_bcnt [4];
    int m_ccnt [4];
    bit m_mask [4];
    bit m_hold [4];
    bit m_act = 1'b0;
    int m_g = 0;
    bit m_ready = 1'b0;

    int e_dack, e_addr, e_dir;
    bit e_xfer, e_tc, e_done, e_end;

    // Monitors for the scenario checks.
    int xcount, tcount, last_addr, last_dir, first_addr, first_gnt, dack_seen;

    task automatic chk(input bit ok, input string name, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", name, act, exp);
        end
    endtask

    task automatic cmp(input logic [31:0] act, input int exp, input string name);
        checks++;
        if (act !== 32'(exp)) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", name, act, exp, $time);
        end
    endtask

    // Expected outputs and decisions from the model state and current inputs.
    task automatic eval();
        int svc;
        bit greq, on;
        svc    = (m_mode[m_g] >> 4) & 3;
        greq   = dreq[m_g];
        on     = m_act && (svc == 1 || svc == 2 || greq);
        e_xfer = on && svc != 3;
        e_dack = on ? (1 << m_g) : 0;
        e_addr = e_xfer ? m_caddr[m_g] : 0;
        e_dir  = e_xfer ? (m_mode[m_g] & 3) : 0;
        e_tc   = e_xfer && m_ccnt[m_g] == 0;
        e_done = e_xfer && (m_ccnt[m_g] == 0 || eop);
        case (svc)
            0:       e_end = !greq || e_done;
            1:       e_end = e_xfer;
            2:       e_end = e_done;
            default: e_end = !greq;
        endcase
        e_end = m_act && e_end;
    endtask

    // Model update on each clock edge.
    always @(posedge clk) begin
        int pick, svc;
        bit aut, dec;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_mode[i] = 0; m_baddr[i] = 0; m_caddr[i] = 0;
                m_bcnt[i] = 0; m_ccnt[i] = 0; m_mask[i] = 1; m_hold[i] = 0;
            end
            m_act = 0; m_g = 0; m_ready = 1;
        end else begin
            eval();
            pick = -1;
            for (int i = 3; i >= 0; i--)
                if (dreq[i] && !m_mask[i] && !m_hold[i]) pick = i;
            if (m_act) begin
                svc = (m_mode[m_g] >> 4) & 3;
                aut = ((m_mode[m_g] >> 2) & 1) != 0;
                dec = ((m_mode[m_g] >> 3) & 1) != 0;
                if (e_xfer) begin
                    if (e_done && aut) begin
                        m_caddr[m_g] = m_baddr[m_g];
                        m_ccnt[m_g]  = m_bcnt[m_g];
                    end else begin
                        m_caddr[m_g] = (dec ? m_caddr[m_g] - 1 : m_caddr[m_g] + 1) & 16'hFFFF;
                        m_ccnt[m_g]  = (m_ccnt[m_g] - 1) & 16'hFFFF;
                    end
                    if (e_done && !aut) m_mask[m_g] = 1;
                    if (svc == 1) m_hold[m_g] = 1;
                end
                if (e_end) m_act = 0;
            end else if (pick >= 0) begin
                m_act = 1;
                m_g = pick;
            end
            for (int i = 0; i < 4; i++)
                if (!dreq[i]) m_hold[i] = 0;
            if (ld_en) begin
                case (ld_sel)
                    2'd0: m_mode[ld_chan] = (int'(ld_data) >> 2) & 63;
                    2'd1: begin m_baddr[ld_chan] = ld_data; m_caddr[ld_chan] = ld_data; end
                    2'd2: begin m_bcnt[ld_chan] = ld_data; m_ccnt[ld_chan] = ld_data; end
                    default: m_mask[ld_chan] = ld_data[0];
                endcase
            end
        end
    end

    // Compare with the model every cycle and collect monitor data.
    always @(negedge clk) begin
        if (rst_n && m_ready && !fin) begin
            eval();
            cmp(32'(dack), e_dack, "R3 dack");
            cmp(32'(xfer), int'(e_xfer), "R5 xfer");
            cmp(32'(addr), e_addr, "R8 addr");
            cmp(32'(dir), e_dir, "R13 dir");
            cmp(32'(tc), int'(e_tc), "R9 tc");
            if (xfer === 1'b1) begin
                xcount++;
                last_addr = addr;
                last_dir = dir;
                if (first_addr < 0) first_addr = addr;
            end
            if (tc === 1'b1) tcount++;
            dack_seen |= int'(dack);
            if (dack != 0 && first_gnt < 0)
                for (int i = 0; i < 4; i++) if (dack[i]) first_gnt = i;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic load(input int ch, input int sel, input int data);
        ld_en = 1'b1;
        ld_chan = 2'(ch);
        ld_sel = 2'(sel);
        ld_data = 16'(data);
        tick(1);
        ld_en = 1'b0;
    endtask

    task automatic clr();
        xcount = 0; tcount = 0; dack_seen = 0; first_addr = -1; first_gnt = -1;
    endtask

    task automatic finish_run();
        fin = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!fin) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        clr();
        rst_n = 1'b0;
        tick(2);
        @(negedge clk);
        chk(dack === 4'b0 && xfer === 1'b0, "R1 reset outputs", int'(dack), 0);
        tick(1);
        rst_n = 1'b1;
        tick(1);
        // R1: all channels start masked.
        clr();
        dreq = 4'hF;
        tick(4);
        chk(dack_seen == 0, "R1 masked after reset", dack_seen, 0);
        dreq = 4'h0;
        tick(1);

        // Single service on channel 1: read, incrementing (R2 R4 R8 R13).
        load(1, 0, 16'h44);
        load(1, 1, 16'h100);
        load(1, 2, 2);
        load(1, 3, 0);
        clr();
        dreq = 4'b0010;
        tick(8);
        chk(xcount == 1, "R4 one transfer per request", xcount, 1);
        chk(last_addr == 16'h100, "R2 loaded address", last_addr, 16'h100);
        chk(last_dir == 1, "R13 read type", last_dir, 1);
        dreq = 4'b0;
        tick(2);
        dreq = 4'b0010;
        tick(4);
        chk(xcount == 2, "R4 re-armed after release", xcount, 2);
        chk(last_addr == 16'h101, "R8 increment", last_addr, 16'h101);
        dreq = 4'b0;
        tick(2);

        // Block service on channel 0: write, decrementing, count 3 (R6 R8 R9 R11).
        load(0, 0, 16'hA8);
        load(0, 1, 16'h200);
        load(0, 2, 3);
        load(0, 3, 0);
        clr();
        dreq = 4'b0001;
        tick(1);
        dreq = 4'b0;
        tick(10);
        chk(xcount == 4, "R6 block runs after request drops", xcount, 4);
        chk(tcount == 1, "R9 single tc pulse", tcount, 1);
        chk(last_addr == 16'h1FD, "R8 decrement", last_addr, 16'h1FD);
        chk(last_dir == 2, "R13 write type", last_dir, 2);
        clr();
        dreq = 4'b0001;
        tick(5);
        chk(dack_seen == 0, "R11 masked after tc", dack_seen, 0);
        dreq = 4'b0;
        tick(1);

        // Demand service on channel 2 with a pause (R5 R9 R11).
        load(2, 0, 16'h04);
        load(2, 1, 16'h300);
        load(2, 2, 9);
        load(2, 3, 0);
        clr();
        dreq = 4'b0100;
        tick(4);
        dreq = 4'b0;
        tick(3);
        chk(xcount >= 1 && xcount < 10, "R5 paused burst", xcount, 3);
        dreq = 4'b0100;
        tick(20);
        chk(xcount == 10, "R5 resumed to completion", xcount, 10);
        chk(tcount == 1, "R9 demand tc", tcount, 1);
        chk(last_addr == 16'h309, "R5 resume from current address", last_addr, 16'h309);
        clr();
        tick(3);
        chk(dack_seen == 0, "R11 demand channel masked", dack_seen, 0);
        dreq = 4'b0;
        tick(1);

        // Priority, then end-of-process on block auto-init channel 3 (R3 R10 R12).
        load(3, 0, 16'h94);
        load(3, 1, 16'h400);
        load(3, 2, 5);
        load(3, 3, 0);
        clr();
        dreq = 4'b1010;
        tick(1);
        dreq = 4'b1000;
        tick(2);
        dreq = 4'b0;
        tick(1);
        eop = 1'b1;
        tick(1);
        eop = 1'b0;
        tick(8);
        chk(first_gnt == 1, "R3 lowest channel wins", first_gnt, 1);
        chk(xcount == 3, "R10 eop ends block burst", xcount, 3);
        chk(tcount == 1, "R9 tc on zero count", tcount, 1);
        clr();
        dreq = 4'b1000;
        tick(1);
        dreq = 4'b0;
        tick(12);
        chk(first_addr == 16'h400, "R12 address reloaded", first_addr, 16'h400);
        chk(xcount == 6, "R12 count reloaded", xcount, 6);
        chk(tcount == 1, "R9 tc after reload", tcount, 1);
        clr();
        dreq = 4'b1000;
        tick(1);
        dreq = 4'b0;
        tick(10);
        chk(xcount == 6, "R12 stays unmasked after tc", xcount, 6);

        // Cascade on channel 1 (R7).
        load(1, 0, 16'hC8);
        load(1, 3, 0);
        clr();
        dreq = 4'b0010;
        tick(5);
        chk(dack_seen == 2, "R7 acknowledge follows request", dack_seen, 2);
        chk(xcount == 0, "R7 no strobe in cascade", xcount, 0);
        dreq = 4'b0;
        tick(2);
        chk(dack === 4'b0, "R7 release on request drop", int'(dack), 0);

        finish_run();
    end

endmodule